// File: doc/BRIEF.md
# Motor Drive Fault and Brake Supervisor

This block sits between the protection flags of a three-phase bridge driver and its gate-drive logic. It takes digital flags from the analog front end: Hall code, supply undervoltage, over-temperature, a per-phase high-side drain-source over-threshold flag and a per-phase bootstrap-charging-busy flag. It also takes a commutation strobe and the controls for disable, brake and brake selection. From these it produces one fault flag, one two-bit override command, and a per-phase permit that gates high-side turn-on.

The override command tells the gate logic to run normally, coast (all gates off), brake (all low sides on, all high sides off) or turn off only the high sides. A power-loss trigger event is either a rising undervoltage or a rising edge of the disable control. At each such event the brake-selection input is stored, and that stored value decides between coast and brake while the disable or undervoltage condition lasts. A lead short to ground is flagged once a high side has been commanded on for a programmable number of cycles and its drain-source flag is still high. That flag is held until the next commutation strobe or until the disable control is asserted.

Top module: `motor_fault_supervisor`

## Requirements
- R1: A Hall code of 3'b000 or 3'b111 sets fault_o. Unless disable or undervoltage is active, it also drives override_o to coast.
- R2: An active over-temperature flag sets fault_o. Unless disable or undervoltage is active, it also drives override_o to coast.
- R3: Undervoltage sets fault_o. Unless disable is active, it drives override_o to brake when the effective stored selection is 1 and to coast when it is 0.
- R4: The stored selection captures brksel_i in any cycle where uv_i or reset_req_i is high and was low in the previous cycle, or was reset low. That cycle already uses the new input value. Changes of brksel_i at any other time have no effect.
- R5: reset_req_i=1 takes highest priority and overrides brake_i. It yields brake (stored selection 1) or coast (stored selection 0), and never run or high-side-off.
- R6: brake_i=1 with no disable, undervoltage, over-temperature or bad Hall code yields brake.
- R7: A phase's short flag sets at a clock edge where hs_on_i of that phase is high, ds_high_i is high, and hs_on_i has already been high for QUAL_CYCLES consecutive earlier edges. A drain-source flag inside that window has no effect.
- R8: Any held short flag sets fault_o. When nothing of higher priority is active, it drives override_o to high-side-off.
- R9: A commutation strobe clears all short flags at that edge. Clearing wins over setting.
- R10: reset_req_i=1 clears all short flags.
- R11: hs_permit_o of a phase is 1 only when override_o is run and that phase's boot_busy_i is 0.
- R12: With no condition active, fault_o is 0 and override_o is run. The override encoding is run=0, coast=1, brake=2, high-side-off=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Hall sensor code |
| uv_i | input | 1 | Supply undervoltage flag |
| tsd_i | input | 1 | Over-temperature flag |
| hs_on_i | input | NUM_PHASES | High side currently commanded on, per phase |
| ds_high_i | input | NUM_PHASES | High-side drain-source above threshold, per phase |
| boot_busy_i | input | NUM_PHASES | Bootstrap charge current still above limit, per phase |
| commutate_i | input | 1 | Commutation event strobe |
| reset_req_i | input | 1 | Disable control, active high |
| brake_i | input | 1 | Dynamic brake request |
| brksel_i | input | 1 | Brake selection: 1 brake, 0 coast |
| fault_o | output | 1 | Fault indication |
| override_o | output | 2 | Gate override command |
| hs_permit_o | output | NUM_PHASES | High-side turn-on permit, per phase |

## Verification
The assertions assume that the input flags are synchronous to clk_i and stable around the rising edge. They also assume the Hall input is exactly three bits wide. The bench changes every input only on the falling edge, so each edge samples settled values. A directed phase holds hs_on_i across the whole qualification window and raises commutation and disable in chosen cycles. A random phase keeps the disable and commutation strobes rare, so that short flags get the chance to form.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic [1:0] {
    OVR_RUN    = 2'b00,
    OVR_COAST  = 2'b01,
    OVR_BRAKE  = 2'b10,
    OVR_HS_OFF = 2'b11
  } ovr_e;
endpackage

// File: rtl/mfs_brake_store.sv
module mfs_brake_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic reset_req_i,
  input  logic brksel_i,
  output logic sel_eff_o
);
  logic uv_q, rr_q, sel_q, trig;

  assign trig      = (uv_i & ~uv_q) | (reset_req_i & ~rr_q);
  assign sel_eff_o = trig ? brksel_i : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_q  <= 1'b0;
      rr_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      uv_q <= uv_i;
      rr_q <= reset_req_i;
      if (trig) sel_q <= brksel_i;
    end
  end
endmodule

// File: rtl/mfs_short_guard.sv
module mfs_short_guard #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_on_i,
  input  logic ds_high_i,
  input  logic clear_i,
  output logic short_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          qualified;

  assign qualified = (cnt_q == QMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      short_o <= 1'b0;
    end else begin
      if (!hs_on_i)       cnt_q <= '0;
      else if (!qualified) cnt_q <= cnt_q + 1'b1;
      if (clear_i)        short_o <= 1'b0;
      else if (hs_on_i && qualified && ds_high_i) short_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mfs_arbiter.sv
module mfs_arbiter
  import mfs_pkg::*;
#(
  parameter int NUM_PHASES = 3
) (
  input  logic [2:0]            hall_i,
  input  logic                  uv_i,
  input  logic                  tsd_i,
  input  logic                  reset_req_i,
  input  logic                  brake_i,
  input  logic                  sel_eff_i,
  input  logic [NUM_PHASES-1:0] short_i,
  input  logic [NUM_PHASES-1:0] boot_busy_i,
  output logic                  fault_o,
  output ovr_e                  ovr_o,
  output logic [NUM_PHASES-1:0] permit_o
);
  logic hall_bad, any_short;
  ovr_e stored_ovr;

  assign hall_bad   = (hall_i == 3'b000) || (hall_i == 3'b111);
  assign any_short  = |short_i;
  assign stored_ovr = sel_eff_i ? OVR_BRAKE : OVR_COAST;
  assign fault_o    = hall_bad | tsd_i | uv_i | any_short;

  always_comb begin
    if (reset_req_i)          ovr_o = stored_ovr;
    else if (uv_i)            ovr_o = stored_ovr;
    else if (hall_bad || tsd_i) ovr_o = OVR_COAST;
    else if (brake_i)         ovr_o = OVR_BRAKE;
    else if (any_short)       ovr_o = OVR_HS_OFF;
    else                      ovr_o = OVR_RUN;
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_permit
    assign permit_o[p] = (ovr_o == OVR_RUN) & ~boot_busy_i[p] & ~short_i[p];
  end
endmodule

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor
  import mfs_pkg::*;
#(
  parameter int NUM_PHASES  = 3,
  parameter int QUAL_CYCLES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            hall_i,
  input  logic                  uv_i,
  input  logic                  tsd_i,
  input  logic [NUM_PHASES-1:0] hs_on_i,
  input  logic [NUM_PHASES-1:0] ds_high_i,
  input  logic [NUM_PHASES-1:0] boot_busy_i,
  input  logic                  commutate_i,
  input  logic                  reset_req_i,
  input  logic                  brake_i,
  input  logic                  brksel_i,
  output logic                  fault_o,
  output logic [1:0]            override_o,
  output logic [NUM_PHASES-1:0] hs_permit_o
);
  logic                  sel_eff;
  logic [NUM_PHASES-1:0] short_q;
  logic                  short_clr;
  ovr_e                  ovr;

  assign short_clr  = commutate_i | reset_req_i;
  assign override_o = ovr;

  mfs_brake_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .uv_i       (uv_i),
    .reset_req_i(reset_req_i),
    .brksel_i   (brksel_i),
    .sel_eff_o  (sel_eff)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    mfs_short_guard #(.QUAL_CYCLES(QUAL_CYCLES)) u_guard (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hs_on_i  (hs_on_i[p]),
      .ds_high_i(ds_high_i[p]),
      .clear_i  (short_clr),
      .short_o  (short_q[p])
    );
  end

  mfs_arbiter #(.NUM_PHASES(NUM_PHASES)) u_arb (
    .hall_i     (hall_i),
    .uv_i       (uv_i),
    .tsd_i      (tsd_i),
    .reset_req_i(reset_req_i),
    .brake_i    (brake_i),
    .sel_eff_i  (sel_eff),
    .short_i    (short_q),
    .boot_busy_i(boot_busy_i),
    .fault_o    (fault_o),
    .ovr_o      (ovr),
    .permit_o   (hs_permit_o)
  );
endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
  parameter int NUM_PHASES = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2:0]            hall_i,
  input logic                  uv_i,
  input logic                  reset_req_i,
  input logic                  commutate_i,
  input logic [NUM_PHASES-1:0] boot_busy_i,
  input logic                  fault_o,
  input logic [1:0]            override_o,
  input logic [NUM_PHASES-1:0] hs_permit_o
);
  a_r1_hall_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hall_i == 3'b000 || hall_i == 3'b111) |-> fault_o);

  a_r3_uv_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> fault_o);

  a_r5_reset_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |-> (override_o == 2'b01 || override_o == 2'b10));

  a_r9_commutate_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commutate_i |=> override_o != 2'b11);

  a_r11_boot_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_permit_o & boot_busy_i) == '0);

  a_r11_permit_only_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hs_permit_o) |-> override_o == 2'b00);
endmodule

bind motor_fault_supervisor mfs_checker #(.NUM_PHASES(NUM_PHASES)) u_chk (.*);

// File: tb/motor_fault_supervisor_test.sv
module motor_fault_supervisor_test;
  localparam int NP = 3;
  localparam int QC = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] hall = 3'b101;
  logic uv = 0, tsd = 0, comm = 0, rr = 0, brk = 0, bsel = 0;
  logic [NP-1:0] hs_on = '0, ds = '0, boot = '0;
  logic fault;
  logic [1:0] ovr;
  logic [NP-1:0] permit;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int  m_cnt [NP];
  bit  m_stg [NP];
  bit  m_sel, m_uvp, m_rrp;

  always #4 clk = ~clk;

  motor_fault_supervisor #(.NUM_PHASES(NP), .QUAL_CYCLES(QC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .uv_i(uv), .tsd_i(tsd),
    .hs_on_i(hs_on), .ds_high_i(ds), .boot_busy_i(boot), .commutate_i(comm),
    .reset_req_i(rr), .brake_i(brk), .brksel_i(bsel),
    .fault_o(fault), .override_o(ovr), .hs_permit_o(permit));

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin m_cnt[p] = 0; m_stg[p] = 0; end
    m_sel = 0; m_uvp = 0; m_rrp = 0;
  endtask

  task automatic model_edge();
    if ((uv && !m_uvp) || (rr && !m_rrp)) m_sel = bsel;
    m_uvp = uv; m_rrp = rr;
    for (int p = 0; p < NP; p++) begin
      if (comm || rr) m_stg[p] = 0;
      else if (hs_on[p] && m_cnt[p] >= QC && ds[p]) m_stg[p] = 1;
      m_cnt[p] = hs_on[p] ? ((m_cnt[p] + 1 > QC) ? QC : m_cnt[p] + 1) : 0;
    end
  endtask

  task automatic compare(input string tag_in);
    logic ef; logic [1:0] eo; logic [NP-1:0] ep;
    bit es, hb, anys;
    string tg;
    es   = ((uv && !m_uvp) || (rr && !m_rrp)) ? bsel : m_sel;
    hb   = (hall == 3'b000) || (hall == 3'b111);
    anys = 0;
    for (int p = 0; p < NP; p++) anys |= m_stg[p];
    ef = hb || tsd || uv || anys;
    if (rr)              begin eo = es ? 2'd2 : 2'd1; tg = "R5";  end
    else if (uv)         begin eo = es ? 2'd2 : 2'd1; tg = "R3";  end
    else if (hb)         begin eo = 2'd1;             tg = "R1";  end
    else if (tsd)        begin eo = 2'd1;             tg = "R2";  end
    else if (brk)        begin eo = 2'd2;             tg = "R6";  end
    else if (anys)       begin eo = 2'd3;             tg = "R8";  end
    else                 begin eo = 2'd0;             tg = "R12"; end
    for (int p = 0; p < NP; p++) ep[p] = (eo == 2'd0) && !boot[p] && !m_stg[p];
    if (tag_in != "") tg = tag_in;
    checks += 3;
    if (fault !== ef) begin errors++; $display("FAIL %s fault_o act=%0b exp=%0b", tg, fault, ef); end
    if (ovr !== eo) begin errors++; $display("FAIL %s override_o act=%0d exp=%0d", tg, ovr, eo); end
    if (permit !== ep) begin errors++; $display("FAIL R11 hs_permit_o act=%b exp=%b", permit, ep); end
  endtask

  task automatic step(input string tag = "");
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R12"); // reset state
    rst_n = 1;
    repeat (3) step("R12");

    hall = 3'b000; step("R1");
    hall = 3'b111; step("R1");
    hall = 3'b011; tsd = 1; step("R2");
    tsd = 0; brk = 1; step("R6");
    tsd = 1; step("R2");
    tsd = 0;

    // disable with brake selected, then selection changes ignored
    bsel = 1; rr = 1; step("R5");
    bsel = 0; repeat (2) step("R4");
    rr = 0; step("R6");
    brk = 0; step("R12");

    // undervoltage: coast, later brksel change ignored, then brake
    bsel = 0; uv = 1; step("R3");
    bsel = 1; repeat (2) step("R4");
    uv = 0; step("R12");
    uv = 1; step("R3");
    bsel = 0; step("R4");
    uv = 0; step("R12");

    // short-to-ground qualification
    hs_on = 3'b001; ds = 3'b001;
    repeat (QC) step("R7");
    step("R7");
    step("R8");
    boot = 3'b100; step("R8");
    comm = 1; step("R9");
    comm = 0; hs_on = 3'b000; ds = '0; step("R9");
    boot = 3'b010; step("R11");
    boot = '0;
    hs_on = 3'b100; ds = 3'b100;
    repeat (QC + 2) step("R7");
    hs_on = '0; ds = '0; step("R8");
    rr = 1; step("R10");
    rr = 0; step("R10");

    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      hall  = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(0, 7)) : 3'b110;
      uv    = ($urandom_range(0, 40) == 0);
      tsd   = ($urandom_range(0, 40) == 0);
      rr    = ($urandom_range(0, 60) == 0);
      brk   = ($urandom_range(0, 30) == 0);
      bsel  = 1'($urandom_range(0, 1));
      comm  = ($urandom_range(0, 25) == 0);
      if ($urandom_range(0, 7) == 0) hs_on = NP'($urandom_range(0, 7));
      ds    = NP'($urandom_range(0, 7));
      boot  = NP'($urandom_range(0, 7)) & NP'($urandom_range(0, 7));
      step();
    end
    finish_run();
  end
endmodule